// File: doc/BRIEF.md
# Transceiver Enable and Activity Indicator

This block turns the activity of one UART channel into two status pins. The first pin always reports transmit activity. The second pin has two uses, chosen by configuration: it can report receive activity, or it can drive the driver/receiver enable of an external half-duplex RS-485 transceiver.

An activity pin sits high while its direction is idle. While traffic flows, the pin blinks at a slow fixed rate that suits an LED. A shared prescaler divides the system clock to set the interval between level changes, and its default value gives 7.5 Hz from a 48 MHz clock.

In transceiver mode, the enable is asserted while the transmitter is busy or a line break is being sent. It stays asserted until one bit time has passed after the final stop bit. Its polarity can be selected.

Top module: `actind_top`

## Requirements
- R1: During and directly after a synchronous reset, `tx_led` is 1. `pin1` is 1 in toggle mode (`pin1_mode`=0) and in transceiver mode with `en_active_low`=1. It is 0 in transceiver mode with `en_active_low`=0.
- R2: The prescaler marks a period boundary on clock edges HALF_PERIOD, 2·HALF_PERIOD, and so on, counted after reset. An activity pin can change level only on a boundary edge. Transmit activity means `tx_busy` or `brk_on` is high.
- R3: At a boundary, a pin whose direction had no activity during the period just ended goes to 1, or stays at 1.
- R4: At a boundary, a pin whose direction was active for any cycle of the period just ended inverts its level. This holds even if the activity lasted only one cycle.
- R5: In toggle mode, `pin1` follows receive activity (`rx_busy`) under the rules of R2 to R4.
- R6: In transceiver mode (`pin1_mode`=1), `pin1` is asserted on the clock edge after `tx_busy` or `brk_on` is seen high. It stays asserted while either input is high.
- R7: A `stop_done` pulse keeps the enable asserted until the first `bit_tick` sampled after the pulse's cycle. A `bit_tick` in the same cycle as `stop_done` does not end the hold. The enable is deasserted on the edge that samples that later tick, provided no transmission or break is active.
- R8: If a transmission starts during the hold, the enable stays asserted with no deasserted cycle in between.
- R9: `en_active_low`=0 makes the asserted enable level 1. `en_active_low`=1 makes the asserted enable level 0.
- R10: In transceiver mode, `rx_busy` has no effect on `pin1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_busy | input | 1 | Transmitter is shifting a character |
| brk_on | input | 1 | Line break is being driven |
| stop_done | input | 1 | Single-cycle pulse when a stop bit completes |
| rx_busy | input | 1 | Receiver is taking in a character |
| bit_tick | input | 1 | Single-cycle pulse once per bit time |
| pin1_mode | input | 1 | 0: receive-activity pin, 1: transceiver enable |
| en_active_low | input | 1 | 1: transceiver enable is active low |
| tx_led | output | 1 | Transmit-activity pin |
| pin1 | output | 1 | Receive-activity pin or transceiver enable |

## Verification
The assertions assume the following about the inputs:
- `stop_done` and `bit_tick` are single-cycle pulses.
- `stop_done` arrives no earlier than the cycle in which the transmitter stops being busy.
- `pin1_mode` and `en_active_low` are constant outside reset.

The stimulus changes configuration only while reset is held. It raises and lowers each activity input on falling clock edges, so every level is sampled for whole cycles. The ticks are placed deliberately, including one that coincides with a stop pulse and one that falls inside a running transmission.

// File: rtl/actind_pkg.sv
package actind_pkg;
  typedef enum logic {
    PIN1_ACTIVITY = 1'b0,
    PIN1_XCVR_EN  = 1'b1
  } pin1_mode_e;

  localparam int unsigned NUM_LEDS = 2;
endpackage

// File: rtl/actind_prescale.sv
module actind_prescale #(
  parameter int unsigned HALF_PERIOD = 3_200_000
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int unsigned CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign strobe = (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/actind_blink.sv
module actind_blink (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic active,
  output logic blink
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen  <= 1'b0;
      blink <= 1'b1;
    end else if (strobe) begin
      seen  <= 1'b0;
      blink <= (seen | active) ? ~blink : 1'b1;
    end else begin
      seen  <= seen | active;
    end
  end

  // R2
  stable_between_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(blink));

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !seen && !active) |=> blink);

  // R4
  active_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && active) |=> (blink != $past(blink)));
endmodule

// File: rtl/actind_xcvr_en.sv
module actind_xcvr_en (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic brk_on,
  input  logic stop_done,
  input  logic bit_tick,
  input  logic active_low,
  output logic en_pin
);
  logic hold;
  logic hold_next;
  logic drive;

  assign hold_next = stop_done | (hold & ~bit_tick);
  assign drive     = tx_busy | brk_on | hold_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= 1'b0;
      en_pin <= active_low;
    end else begin
      hold   <= hold_next;
      en_pin <= drive ^ active_low;
    end
  end

  // R6
  drive_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy || brk_on) |=> (en_pin != active_low));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stop_done |=> (en_pin != active_low));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && bit_tick && !stop_done && !tx_busy && !brk_on) |=> (en_pin == active_low));
endmodule

// File: rtl/actind_top.sv
module actind_top #(
  parameter int unsigned HALF_PERIOD = 3_200_000
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_busy,
  input  logic brk_on,
  input  logic stop_done,
  input  logic rx_busy,
  input  logic bit_tick,
  input  logic pin1_mode,
  input  logic en_active_low,
  output logic tx_led,
  output logic pin1
);
  import actind_pkg::*;

  logic                strobe;
  logic [NUM_LEDS-1:0] act_vec;
  logic [NUM_LEDS-1:0] blink_vec;
  logic                en_pin;
  pin1_mode_e          mode_e;

  assign mode_e  = pin1_mode_e'(pin1_mode);
  assign act_vec = {rx_busy, tx_busy | brk_on};

  actind_prescale #(.HALF_PERIOD(HALF_PERIOD)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
    actind_blink u_blink (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .active (act_vec[g]),
      .blink  (blink_vec[g])
    );
  end

  actind_xcvr_en u_en (
    .clk        (clk),
    .rst        (rst),
    .tx_busy    (tx_busy),
    .brk_on     (brk_on),
    .stop_done  (stop_done),
    .bit_tick   (bit_tick),
    .active_low (en_active_low),
    .en_pin     (en_pin)
  );

  assign tx_led = blink_vec[0];
  assign pin1   = (mode_e == PIN1_XCVR_EN) ? en_pin : blink_vec[1];

  // R10
  xcvr_ignores_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_e == PIN1_XCVR_EN && (tx_busy || brk_on)) |=> (pin1 != en_active_low));
endmodule

// File: tb/tb_actind_top.sv
module tb_actind_top;
  localparam int unsigned HP = 8;

  typedef struct {
    int    cyc;
    bit    p0;
    bit    p1;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_busy = 0, brk_on = 0, stop_done = 0, rx_busy = 0, bit_tick = 0;
  logic pin1_mode = 0, en_active_low = 0;
  logic tx_led, pin1;

  int   cyc;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  actind_top #(.HALF_PERIOD(HP)) dut (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .brk_on(brk_on),
    .stop_done(stop_done), .rx_busy(rx_busy), .bit_tick(bit_tick),
    .pin1_mode(pin1_mode), .en_active_low(en_active_low),
    .tx_led(tx_led), .pin1(pin1)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic push(input int c, input bit p0, input bit p1, input string tag);
    exp_t e;
    e.cyc = c; e.p0 = p0; e.p1 = p1; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare the queued expectations in the cycle they fall due
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        checks++;
        if (q[0].cyc < cyc) begin
          errors++;
          $display("FAIL %s: expectation for cycle %0d missed", q[0].tag, q[0].cyc);
        end else if (tx_led !== q[0].p0 || pin1 !== q[0].p1) begin
          errors++;
          $display("FAIL %s cyc %0d: actual tx_led=%b pin1=%b expected tx_led=%b pin1=%b",
                   q[0].tag, cyc, tx_led, pin1, q[0].p0, q[0].p1);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_reset(input bit mode, input bit pol, input bit exp_p1);
    @(negedge clk);
    rst = 1'b1;
    tx_busy = 0; brk_on = 0; stop_done = 0; rx_busy = 0; bit_tick = 0;
    pin1_mode = mode; en_active_low = pol;
    repeat (2) @(negedge clk);
    checks++;
    if (tx_led !== 1'b1 || pin1 !== exp_p1) begin
      errors++;
      $display("FAIL R1 reset: actual tx_led=%b pin1=%b expected tx_led=1 pin1=%b",
               tx_led, pin1, exp_p1);
    end
    rst = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // A: transmit activity blinks, then returns high (R1 R2 R3 R4)
    do_reset(1'b0, 1'b0, 1'b1);
    push(5, 1, 1, "R2 before first boundary");
    push(8, 0, 1, "R4 first flip");
    push(11, 0, 1, "R2 steady between boundaries");
    push(16, 1, 1, "R4 second flip");
    push(24, 0, 1, "R4 flip from late activity");
    push(31, 0, 1, "R2 steady");
    push(32, 1, 1, "R3 idle goes high");
    push(40, 1, 1, "R3 idle stays high");
    wait_cyc(0); tx_busy = 1;
    wait_cyc(18); tx_busy = 0;
    drain();

    // B: one-cycle receive pulse is captured (R4 R5)
    do_reset(1'b0, 1'b0, 1'b1);
    push(7, 1, 1, "R5 before boundary");
    push(8, 1, 0, "R4 R5 short pulse flips");
    push(15, 1, 0, "R5 steady");
    push(16, 1, 1, "R3 R5 idle high");
    push(24, 1, 1, "R3 R5 stays high");
    wait_cyc(2); rx_busy = 1;
    wait_cyc(3); rx_busy = 0;
    drain();

    // C: transceiver enable, active high (R1 R6 R7 R9 R10)
    do_reset(1'b1, 1'b0, 1'b0);
    push(2, 1, 0, "R9 enable idle low");
    push(3, 1, 1, "R6 asserted after busy");
    push(13, 0, 1, "R7 held after stop");
    push(14, 0, 0, "R7 released by tick");
    push(16, 1, 0, "R3 tx pin high");
    push(24, 1, 0, "R10 rx ignored");
    push(25, 1, 0, "R10 rx ignored");
    wait_cyc(2);  tx_busy = 1;
    wait_cyc(10); tx_busy = 0; stop_done = 1;
    wait_cyc(11); stop_done = 0;
    wait_cyc(13); bit_tick = 1;
    wait_cyc(14); bit_tick = 0;
    wait_cyc(20); rx_busy = 1;
    wait_cyc(22); rx_busy = 0;
    drain();

    // D: active low, break, retrigger during hold, tick with stop (R6 R7 R8 R9 R10)
    do_reset(1'b1, 1'b1, 1'b1);
    rx_busy = 1;
    for (int c = 1; c <= 24; c++) begin
      bit p0;
      bit p1;
      p0 = (c < 8) ? 1'b1 : ((c < 16) ? 1'b0 : 1'b1);
      p1 = (c >= 3 && c <= 20) ? 1'b0 : 1'b1;
      push(c, p0, p1, "R8 R9 R7 R10 low-active sequence");
    end
    wait_cyc(2);  brk_on = 1;
    wait_cyc(6);  brk_on = 0; stop_done = 1;
    wait_cyc(7);  stop_done = 0;
    wait_cyc(8);  tx_busy = 1;
    wait_cyc(9);  bit_tick = 1;
    wait_cyc(10); bit_tick = 0;
    wait_cyc(15); tx_busy = 0; stop_done = 1; bit_tick = 1;
    wait_cyc(16); stop_done = 0; bit_tick = 0;
    wait_cyc(20); bit_tick = 1;
    wait_cyc(21); bit_tick = 0;
    drain();
    rx_busy = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule